// File: doc/BRIEF.md
# Double-Write Protected Configuration Register

This block holds one configuration word behind a two-step commit. Software writes a value once to arm it. A second write with the identical value makes it the live setting. If the second write carries a different value, the live setting is kept and a one-cycle update-error pulse is raised. A read of the register discards an armed value, so software can always start a fresh write pair.

Next to the live copy the block keeps a second copy that holds the bitwise inverse. The two copies are compared every cycle. Any disagreement is a fatal storage error. Such a disagreement can come from a fault, or from a pulse on only one of the two resets after the word has been changed from its reset value. The storage error is latched until the main reset, and while it is present every write is ignored. The copies use separate reset inputs, so a glitch on either reset shows up as a disagreement.

Top module: `shadow_cfg_reg`

## Requirements
- R1: After both resets, `value_o` equals `RESET_VAL` (default 0) and `update_err_o`, `storage_err_o`, `stat_update_err_o` and `stat_storage_err_o` are all 0.
- R2: A write accepted while nothing is armed stores the data as the armed value and leaves `value_o` unchanged.
- R3: A write whose data equals the armed value commits it: `value_o` shows the new data from the clock edge that samples that write. The armed value is then cleared.
- R4: A second write whose data differs from the armed value leaves `value_o` unchanged and clears the armed value. It raises `update_err_o` for exactly one cycle, following that edge.
- R5: `stat_update_err_o` rises together with the first `update_err_o` pulse and stays 1 until the main reset.
- R6: A read (`rd_en_i`=1) clears the armed value. A write in the same cycle as a read is treated as a first write.
- R7: The second copy holds the inverse of the committed value. As soon as the copies disagree, `storage_err_o` is 1. `stat_storage_err_o` is 1 from the next clock edge onward, and both stay 1 until the main reset.
- R8: While `storage_err_o` is 1, writes are ignored: `value_o` does not change and no update error is raised.
- R9: Pulsing only `shadow_rst_ni` or only `rst_ni` after a non-reset value was committed causes a storage error. The same pulse while the committed value still equals `RESET_VAL` causes none.
- R10: Either reset clears the armed value, so the next two equal writes commit without an update error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Main asynchronous reset, active low; resets the live copy and the error latches |
| shadow_rst_ni | input | 1 | Asynchronous reset of the inverted copy, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read strobe; discards the armed value |
| value_o | output | WIDTH | Committed value |
| update_err_o | output | 1 | One-cycle pulse on a mismatching second write |
| storage_err_o | output | 1 | Fatal storage error, immediate and sticky |
| stat_update_err_o | output | 1 | Sticky update-error status bit |
| stat_storage_err_o | output | 1 | Latched storage-error status bit |

## Verification
A commit and an update-error pulse both appear after the single clock edge that samples the second write. So every table step drives inputs at the falling edge and samples one time unit after the next rising edge. `storage_err_o` follows a copy disagreement without a clock, so it is checked right after a reset pulse is released. `stat_storage_err_o` needs one more edge and is sampled after it. Blocked writes are checked by reading `value_o` and the update flags after two equal writes have been issued during an active storage error.

// File: rtl/shadow_reg_pkg.sv
package shadow_reg_pkg;

  typedef enum logic {
    PH_EMPTY = 1'b0,
    PH_ARMED = 1'b1
  } phase_e;

  typedef struct packed {
    logic upd;
    logic stor;
  } err_stat_t;

endpackage

// File: rtl/shadow_stage.sv
module shadow_stage
  import shadow_reg_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shadow_rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             block_i,
  output logic             commit_o,
  output logic             upd_mismatch_o
);

  function automatic logic same_word(input logic [WIDTH-1:0] a,
                                     input logic [WIDTH-1:0] b);
    return (a ^ b) == '0;
  endfunction

  logic             any_rst_n;
  phase_e           phase_q, phase_eff;
  logic [WIDTH-1:0] staged_q;
  logic             accept, second;

  assign any_rst_n = rst_ni & shadow_rst_ni;
  assign accept    = wr_en_i & ~block_i;
  assign phase_eff = rd_en_i ? PH_EMPTY : phase_q;
  assign second    = accept && (phase_eff == PH_ARMED);

  assign commit_o       = second &&  same_word(staged_q, wr_data_i);
  assign upd_mismatch_o = second && !same_word(staged_q, wr_data_i);

  always_ff @(posedge clk_i or negedge any_rst_n) begin
    if (!any_rst_n) begin
      phase_q  <= PH_EMPTY;
      staged_q <= '0;
    end else if (accept) begin
      if (phase_eff == PH_EMPTY) begin
        phase_q  <= PH_ARMED;
        staged_q <= wr_data_i;
      end else begin
        phase_q  <= PH_EMPTY;
      end
    end else if (rd_en_i) begin
      phase_q <= PH_EMPTY;
    end
  end

endmodule

// File: rtl/shadow_store.sv
module shadow_store #(
  parameter int               WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shadow_rst_ni,
  input  logic             commit_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] committed_o,
  output logic             mismatch_o
);

  function automatic logic [WIDTH-1:0] to_shadow(input logic [WIDTH-1:0] v);
    return ~v;
  endfunction

  function automatic logic copies_agree(input logic [WIDTH-1:0] c,
                                        input logic [WIDTH-1:0] s);
    return (c ^ s) == '1;
  endfunction

  localparam logic [WIDTH-1:0] ShadowResetVal = ~RESET_VAL;

  logic [WIDTH-1:0] live_q, inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       live_q <= RESET_VAL;
    else if (commit_i) live_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge shadow_rst_ni) begin
    if (!shadow_rst_ni) inv_q <= ShadowResetVal;
    else if (commit_i)  inv_q <= to_shadow(data_i);
  end

  assign committed_o = live_q;
  assign mismatch_o  = !copies_agree(live_q, inv_q);

endmodule

// File: rtl/shadow_err_mon.sv
module shadow_err_mon
  import shadow_reg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mismatch_i,
  input  logic      upd_mismatch_i,
  output logic      upd_pulse_o,
  output logic      storage_err_o,
  output err_stat_t stat_o
);

  logic stor_q, upd_pulse_q, upd_sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stor_q       <= 1'b0;
      upd_pulse_q  <= 1'b0;
      upd_sticky_q <= 1'b0;
    end else begin
      stor_q       <= stor_q | mismatch_i;
      upd_pulse_q  <= upd_mismatch_i;
      upd_sticky_q <= upd_sticky_q | upd_mismatch_i;
    end
  end

  assign upd_pulse_o   = upd_pulse_q;
  assign storage_err_o = stor_q | mismatch_i;
  assign stat_o.upd    = upd_sticky_q;
  assign stat_o.stor   = stor_q;

endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg
  import shadow_reg_pkg::*;
#(
  parameter int               WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shadow_rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] value_o,
  output logic             update_err_o,
  output logic             storage_err_o,
  output logic             stat_update_err_o,
  output logic             stat_storage_err_o
);

  logic      commit_evt;
  logic      upd_mismatch_evt;
  logic      copy_mismatch;
  err_stat_t err_stat;

  shadow_stage #(.WIDTH(WIDTH)) u_stage (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .shadow_rst_ni  (shadow_rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_en_i        (rd_en_i),
    .block_i        (storage_err_o),
    .commit_o       (commit_evt),
    .upd_mismatch_o (upd_mismatch_evt)
  );

  shadow_store #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .shadow_rst_ni (shadow_rst_ni),
    .commit_i      (commit_evt),
    .data_i        (wr_data_i),
    .committed_o   (value_o),
    .mismatch_o    (copy_mismatch)
  );

  shadow_err_mon u_err (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mismatch_i     (copy_mismatch),
    .upd_mismatch_i (upd_mismatch_evt),
    .upd_pulse_o    (update_err_o),
    .storage_err_o  (storage_err_o),
    .stat_o         (err_stat)
  );

  assign stat_update_err_o  = err_stat.upd;
  assign stat_storage_err_o = err_stat.stor;

endmodule

// File: rtl/shadow_cfg_reg_chk.sv
module shadow_cfg_reg_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] value_o,
  input logic             update_err_o,
  input logic             storage_err_o,
  input logic             stat_update_err_o,
  input logic             stat_storage_err_o,
  input logic             commit_evt,
  input logic             copy_mismatch
);

  assert_commit_loads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_evt |=> value_o == $past(wr_data_i));

  assert_upd_err_keeps_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_err_o |-> value_o == $past(value_o));

  assert_upd_err_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_err_o |=> !update_err_o);

  assert_upd_status_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_update_err_o |=> stat_update_err_o);

  assert_mismatch_latches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_mismatch |=> stat_storage_err_o);

  assert_storage_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_storage_err_o |=> stat_storage_err_o && storage_err_o);

  assert_blocked_no_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    storage_err_o |=> $stable(value_o) && !update_err_o);

endmodule

bind shadow_cfg_reg shadow_cfg_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .wr_data_i          (wr_data_i),
  .value_o            (value_o),
  .update_err_o       (update_err_o),
  .storage_err_o      (storage_err_o),
  .stat_update_err_o  (stat_update_err_o),
  .stat_storage_err_o (stat_storage_err_o),
  .commit_evt         (commit_evt),
  .copy_mismatch      (copy_mismatch)
);

// File: tb/tb_shadow_cfg_reg.sv
module tb_shadow_cfg_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 11;

  // {wr, rd, data, expected value, expected pulse, expected sticky status}
  typedef struct packed {
    logic         wr;
    logic         rd;
    logic [W-1:0] data;
    logic [W-1:0] exp_val;
    logic         exp_pulse;
    logic         exp_stat;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 32'h0000_00A5, 32'h0000_0000, 1'b0, 1'b0}, // R2 first write
    '{1'b1, 1'b0, 32'h0000_00A5, 32'h0000_00A5, 1'b0, 1'b0}, // R3 commit
    '{1'b1, 1'b0, 32'h0000_0011, 32'h0000_00A5, 1'b0, 1'b0}, // R2
    '{1'b1, 1'b0, 32'h0000_0022, 32'h0000_00A5, 1'b1, 1'b1}, // R4 mismatch
    '{1'b0, 1'b0, 32'h0000_0000, 32'h0000_00A5, 1'b0, 1'b1}, // R4 one cycle, R5
    '{1'b1, 1'b0, 32'h0000_0033, 32'h0000_00A5, 1'b0, 1'b1}, // R2
    '{1'b0, 1'b1, 32'h0000_0000, 32'h0000_00A5, 1'b0, 1'b1}, // R6 read clears
    '{1'b1, 1'b0, 32'h0000_0044, 32'h0000_00A5, 1'b0, 1'b1}, // R6 first again
    '{1'b1, 1'b0, 32'h0000_0044, 32'h0000_0044, 1'b0, 1'b1}, // R6 commit
    '{1'b1, 1'b1, 32'h0000_0055, 32'h0000_0044, 1'b0, 1'b1}, // R6 rd+wr stages
    '{1'b1, 1'b0, 32'h0000_0055, 32'h0000_0055, 1'b0, 1'b1}  // R6 commit
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         shadow_rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         rd_en_i = 1'b0;
  logic [W-1:0] value_o;
  logic         update_err_o, storage_err_o, stat_update_err_o, stat_storage_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shadow_cfg_reg #(.WIDTH(W), .RESET_VAL('0)) dut (
    .clk_i, .rst_ni, .shadow_rst_ni, .wr_en_i, .wr_data_i, .rd_en_i,
    .value_o, .update_err_o, .storage_err_o, .stat_update_err_o, .stat_storage_err_o
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [W-1:0] d);
    @(negedge clk_i);
    wr_en_i = wr; rd_en_i = rd; wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic full_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; shadow_rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1; shadow_rst_ni = 1'b1;
  endtask

  initial begin
    full_reset();
    #1;
    check("R1 value", value_o, '0);
    check("R1 flags", {28'd0, update_err_o, storage_err_o, stat_update_err_o, stat_storage_err_o}, '0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].wr, VECS[i].rd, VECS[i].data);
      check($sformatf("R2/R3/R4/R6 vec%0d value", i), value_o, VECS[i].exp_val);
      check($sformatf("R4 vec%0d pulse", i), {31'd0, update_err_o}, {31'd0, VECS[i].exp_pulse});
      check($sformatf("R5 vec%0d status", i), {31'd0, stat_update_err_o}, {31'd0, VECS[i].exp_stat});
    end

    // R10 / R9 harmless case: arm, shadow-only reset while committed is reset value
    full_reset();
    step(1'b1, 1'b0, 32'h0000_0BAD);
    @(negedge clk_i); shadow_rst_ni = 1'b0;
    @(negedge clk_i); shadow_rst_ni = 1'b1;
    #1;
    check("R9 no storage err before write", {31'd0, storage_err_o}, 32'd0);
    check("R5 cleared by reset", {31'd0, stat_update_err_o}, 32'd0);
    step(1'b1, 1'b0, 32'h0000_1234);
    step(1'b1, 1'b0, 32'h0000_1234);
    check("R10 commit after reset clears armed", value_o, 32'h0000_1234);
    check("R10 no update err", {31'd0, stat_update_err_o}, 32'd0);

    // R9 shadow-only glitch after commit -> R7 storage error
    @(negedge clk_i); shadow_rst_ni = 1'b0;
    @(negedge clk_i); shadow_rst_ni = 1'b1;
    #1;
    check("R7 storage_err immediate", {31'd0, storage_err_o}, 32'd1);
    @(posedge clk_i); #1;
    check("R9 shadow glitch status", {31'd0, stat_storage_err_o}, 32'd1);

    // R8 writes blocked
    step(1'b1, 1'b0, 32'h0000_0777);
    step(1'b1, 1'b0, 32'h0000_0777);
    check("R8 value unchanged", value_o, 32'h0000_1234);
    step(1'b1, 1'b0, 32'h0000_0778);
    check("R8 no update err", {30'd0, update_err_o, stat_update_err_o}, 32'd0);
    repeat (3) @(posedge clk_i);
    #1;
    check("R7 sticky", {30'd0, storage_err_o, stat_storage_err_o}, 32'd3);

    // R9 main-only glitch after commit
    full_reset();
    #1;
    check("R1 storage cleared", {30'd0, storage_err_o, stat_storage_err_o}, 32'd0);
    step(1'b1, 1'b0, 32'h0000_0099);
    step(1'b1, 1'b0, 32'h0000_0099);
    check("R3 commit 99", value_o, 32'h0000_0099);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    check("R9 main glitch value reset", value_o, '0);
    check("R9 main glitch storage_err", {31'd0, storage_err_o}, 32'd1);
    @(posedge clk_i); #1;
    check("R9 main glitch status", {31'd0, stat_storage_err_o}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule